// File: doc/BRIEF.md
# Boot-Aware CE1 Chip-Select Decoder

This block turns one signal-processor node's accesses to its 4 MB CE1 external region into chip selects. Out of reset the node is still booting, so every CE1 access goes to the boot EEPROM on the expansion module, and none of the run-time targets can be reached. The boot code ends this phase by changing the level of the node's timer-0 output pin. From the first such change until the next reset, the decoder applies the run-time map instead. That map holds the global shared SRAM, three access styles for the inter-board link (standard, fast, ready-controlled), the PCI bridge registers, a local page register, the VME bridge registers, a read-only interrupt-acknowledge space, and a 1 MB window into VME space.

The address is the word offset from the base of CE1, which is bit 21 down to bit 2 of the byte address. Selects are combinational from the strobe and the offset. The page register supplies bits 31:20 of the VME address that is formed for window accesses. A strap tells the decoder whether it sits on the node that owns the link. On any other node the link ranges are reserved. A reserved access asserts no select, reads as zero, and raises an error pulse.

Top module: `ce1_boot_decoder`

## Requirements
- R1: While reset is active and after it is released, the decoder is in boot mode and the page register is zero. In boot mode a strobe at any offset asserts only select bit 0 (boot ROM) and never raises the error pulse.
- R2: On the first rising clock edge after reset release, the decoder samples the timer pin as its reference level. At the first later rising edge where the pin differs from that level, it switches to run mode. It stays in run mode, whatever the pin does, until reset.
- R3: The select vector is one-hot or zero, and it is zero whenever the strobe is low. The bits are: 0 boot ROM, 1 shared SRAM, 2 standard link, 3 fast link, 4 ready-controlled link, 5 PCI bridge registers, 6 page register, 7 VME bridge registers, 8 interrupt-acknowledge, 9 VME window.
- R4: In run mode, byte offsets 0x000000–0x1FFFFF (addresses 0x0140_0000–0x015F_FFFC) select the shared SRAM.
- R5: In run mode with the strap high, byte offsets 0x200000–0x23FFFF select the standard link, 0x240000–0x27FFFF the fast link, and 0x280000–0x2BFFFF the ready-controlled link. The ready-mode output is high exactly when the ready-controlled link is selected.
- R6: In run mode with the strap low, the three link ranges are reserved.
- R7: In run mode, byte offsets 0x2C0000–0x2C1FFF select the PCI bridge registers and 0x2E0000–0x2E7FFF the VME bridge registers, for reads and for writes. Reads of 0x2F0000–0x2FFFFF select interrupt-acknowledge; writes there are reserved.
- R8: The page register is at byte offsets 0x2D0000–0x2D7FFF. A write there loads it from the write data at the clock edge. A read there returns it zero-extended on the read-data output. Every other access leaves it unchanged.
- R9: The VME address output always equals {page register, offset bits 17:0, 2'b00}. Byte offsets 0x300000–0x3FFFFF select the VME window.
- R10: In run mode, a reserved offset (any byte offset not listed in R4–R9) asserts no select and gives zero read data. In the cycle after the first strobe cycle of that access, the error output is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | CE1 access strobe, active high |
| wrEn | input | 1 | 1 = write, 0 = read |
| offset | input | 20 | Word offset from the base of CE1 |
| wrData | input | 12 | Write data for the page register |
| timerPin | input | 1 | Timer-0 output pin of the node |
| nodeA | input | 1 | Strap: high on the node that owns the link |
| sel | output | 10 | One-hot target selects |
| readyMode | output | 1 | Ready-controlled link access in progress |
| rdData | output | 32 | Page register read data, zero otherwise |
| vmeAddr | output | 32 | Extended VME byte address for window accesses |
| errPulse | output | 1 | One-cycle pulse after a reserved access |

## Verification
The assertions assume that the timer pin is stable while reset is active and through the first clock after release. They also assume that the strap does not change while a strobe is high. The stimulus holds the pin constant across every reset and changes the strap only between phases, with the strobe low. Each access is a single strobe cycle followed by one idle cycle. This keeps the error pulse tied to exactly one access and lets the page register be read back between writes. Random offsets cover every region and the reserved gaps. Directed cases test the range edges, writes to interrupt-acknowledge, the second reset with the pin held high, and a pin that toggles back.

// File: rtl/ce1_pkg.sv
package ce1_pkg;
  localparam int SEL_W    = 10;
  localparam int SEL_BOOT = 0;
  localparam int SEL_SRAM = 1;
  localparam int SEL_LSTD = 2;
  localparam int SEL_LFST = 3;
  localparam int SEL_LRDY = 4;
  localparam int SEL_PCI  = 5;
  localparam int SEL_PAGE = 6;
  localparam int SEL_VREG = 7;
  localparam int SEL_IACK = 8;
  localparam int SEL_VWIN = 9;

  typedef struct packed {
    logic pageWr;
    logic pageRd;
  } ce1_strobe_t;
endpackage

// File: rtl/ce1_ctrl.sv
module ce1_ctrl
  import ce1_pkg::*;
#(
  parameter int HI_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobe,
  input  logic             wrEn,
  input  logic             nodeA,
  input  logic             timerPin,
  input  logic [HI_W-1:0]  offHi,
  output logic [SEL_W-1:0] sel,
  output logic             readyMode,
  output logic             errPulse,
  output ce1_strobe_t      strb
);
  localparam int B_TOP = HI_W - 1;   // offset bit 19
  localparam int B_WIN = HI_W - 2;   // offset bit 18

  logic refValid, refLevel, runMode, strobeQ, reserved;
  logic [SEL_W-1:0] hit;

  // R2 mode latch: sample reference, then arm on first level change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refValid <= 1'b0;
      refLevel <= 1'b0;
      runMode  <= 1'b0;
    end else if (!refValid) begin
      refValid <= 1'b1;
      refLevel <= timerPin;
    end else if (timerPin != refLevel) begin
      runMode <= 1'b1;
    end
  end

  // region decode
  always_comb begin
    hit      = '0;
    reserved = 1'b0;
    if (!runMode) begin
      hit[SEL_BOOT] = 1'b1;
    end else if (!offHi[B_TOP]) begin
      hit[SEL_SRAM] = 1'b1;
    end else if (offHi[B_WIN]) begin
      hit[SEL_VWIN] = 1'b1;
    end else begin
      case (offHi[6:5])
        2'd0: if (nodeA) hit[SEL_LSTD] = 1'b1; else reserved = 1'b1;
        2'd1: if (nodeA) hit[SEL_LFST] = 1'b1; else reserved = 1'b1;
        2'd2: if (nodeA) hit[SEL_LRDY] = 1'b1; else reserved = 1'b1;
        default: begin
          if (offHi[4:0] == 5'b00000)      hit[SEL_PCI]  = 1'b1;
          else if (offHi[4:2] == 3'b010)   hit[SEL_PAGE] = 1'b1;
          else if (offHi[4:2] == 3'b100)   hit[SEL_VREG] = 1'b1;
          else if (offHi[4:3] == 2'b11 && !wrEn) hit[SEL_IACK] = 1'b1;
          else reserved = 1'b1;
        end
      endcase
    end
  end

  assign sel         = strobe ? hit : '0;
  assign readyMode   = sel[SEL_LRDY];
  assign strb.pageWr = sel[SEL_PAGE] & wrEn;
  assign strb.pageRd = sel[SEL_PAGE] & ~wrEn;

  // R10 error pulse on first strobe cycle of a reserved access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ  <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      strobeQ  <= strobe;
      errPulse <= strobe & ~strobeQ & reserved;
    end
  end

  a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    runMode |=> runMode);
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |-> (sel == '0));
  a_r1_boot_only: assert property (@(posedge clk) disable iff (!rstN)
    !runMode |-> (sel[SEL_W-1:1] == '0));
  a_r6_no_link: assert property (@(posedge clk) disable iff (!rstN)
    !nodeA |-> (sel[SEL_LRDY:SEL_LSTD] == 3'b000));
  a_r10_err_single: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);
  a_r1_boot_no_err: assert property (@(posedge clk) disable iff (!rstN)
    !runMode |=> !errPulse);
endmodule

// File: rtl/ce1_dpath.sv
module ce1_dpath
  import ce1_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int LOW_W  = 18,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ce1_strobe_t       strb,
  input  logic [PAGE_W-1:0] wrData,
  input  logic [LOW_W-1:0]  offLo,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] vmeAddr
);
  localparam int PAD_W = DATA_W - PAGE_W;

  logic [PAGE_W-1:0] pageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pageQ <= '0;
    else if (strb.pageWr) pageQ <= wrData;
  end

  assign rdData  = strb.pageRd ? {{PAD_W{1'b0}}, pageQ} : '0;
  assign vmeAddr = {pageQ, offLo, 2'b00};

  a_r8_page_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pageWr |=> $stable(pageQ));
  a_r8_page_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.pageWr |=> (pageQ == $past(wrData)));
endmodule

// File: rtl/ce1_boot_decoder.sv
module ce1_boot_decoder
  import ce1_pkg::*;
#(
  parameter int OFF_W  = 20,
  parameter int PAGE_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobe,
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PAGE_W-1:0] wrData,
  input  logic              timerPin,
  input  logic              nodeA,
  output logic [SEL_W-1:0]  sel,
  output logic              readyMode,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] vmeAddr,
  output logic              errPulse
);
  localparam int HI_LSB = 11;
  localparam int HI_W   = OFF_W - HI_LSB;
  localparam int LOW_W  = OFF_W - 2;

  ce1_strobe_t strb;

  ce1_ctrl #(.HI_W(HI_W)) uCtrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .nodeA(nodeA),
    .timerPin(timerPin), .offHi(offset[OFF_W-1:HI_LSB]), .sel(sel),
    .readyMode(readyMode), .errPulse(errPulse), .strb(strb)
  );

  ce1_dpath #(.PAGE_W(PAGE_W), .LOW_W(LOW_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .offLo(offset[LOW_W-1:0]), .rdData(rdData), .vmeAddr(vmeAddr)
  );
endmodule

// File: tb/tb_ce1_boot_decoder.sv
`timescale 1ns/1ps
module tb_ce1_boot_decoder;
  logic clk = 1'b0, rstN = 1'b0, strobe = 1'b0, wrEn = 1'b0;
  logic timerPin = 1'b0, nodeA = 1'b1;
  logic [19:0] offset = '0;
  logic [11:0] wrData = '0;
  logic [9:0]  sel;
  logic        readyMode, errPulse;
  logic [31:0] rdData, vmeAddr;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mRun = 0;
  logic [11:0] mPage = '0;

  always #2.5 clk = ~clk;

  ce1_boot_decoder dut (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .offset(offset),
    .wrData(wrData), .timerPin(timerPin), .nodeA(nodeA), .sel(sel),
    .readyMode(readyMode), .rdData(rdData), .vmeAddr(vmeAddr), .errPulse(errPulse)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] expSel(input logic [19:0] o, input logic w);
    logic [21:0] b;
    b = {o, 2'b00};
    if (!mRun) return 10'b1;
    if (b < 22'h200000) return 10'b1 << 1;
    if (b >= 22'h300000) return 10'b1 << 9;
    if (b < 22'h240000) return nodeA ? 10'b1 << 2 : 10'b0;
    if (b < 22'h280000) return nodeA ? 10'b1 << 3 : 10'b0;
    if (b < 22'h2C0000) return nodeA ? 10'b1 << 4 : 10'b0;
    if (b < 22'h2C2000) return 10'b1 << 5;
    if (b >= 22'h2D0000 && b < 22'h2D8000) return 10'b1 << 6;
    if (b >= 22'h2E0000 && b < 22'h2E8000) return 10'b1 << 7;
    if (b >= 22'h2F0000 && !w) return 10'b1 << 8;
    return 10'b0;
  endfunction

  task automatic acc(input logic [19:0] o, input logic w, input logic [11:0] d);
    logic [9:0] e;
    @(negedge clk);
    strobe = 1'b1; offset = o; wrEn = w; wrData = d;
    #1;
    e = expSel(o, w);
    chk(sel == e, "R3/R4/R5/R6/R7 sel", sel, e);
    chk(readyMode == e[4], "R5 readyMode", readyMode, e[4]);
    chk(rdData == ((e[6] && !w) ? {20'b0, mPage} : 32'b0), "R8/R10 rdData", rdData,
        (e[6] && !w) ? {20'b0, mPage} : 32'b0);
    chk(vmeAddr == {mPage, o[17:0], 2'b00}, "R9 vmeAddr", vmeAddr, {mPage, o[17:0], 2'b00});
    @(negedge clk);
    strobe = 1'b0;
    if (e[6] && w) mPage = d;
    chk(errPulse == (mRun && e == 10'b0), "R10 errPulse", errPulse, (mRun && e == 10'b0));
  endtask

  task automatic doReset(input logic pin);
    @(negedge clk);
    rstN = 1'b0; timerPin = pin; mRun = 0; mPage = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    #1;
    chk(sel == 10'b0 && errPulse == 1'b0, "R1 sel/err in reset", {sel, errPulse}, 0);
    chk(vmeAddr == 32'h0, "R1 page zero in reset", vmeAddr, 0);
    doReset(1'b0);
    // R1 boot mode: everything goes to boot ROM
    acc(20'h00000, 1'b0, 12'h0);
    acc(20'hB4000, 1'b1, 12'hABC);   // page write ignored in boot
    acc(20'hB2000, 1'b0, 12'h0);     // reserved in run, boot here
    acc(20'hFFFFF, 1'b0, 12'h0);
    chk(vmeAddr[31:20] == 12'h0, "R1 page untouched in boot", vmeAddr[31:20], 0);
    // R2 switch by timer edge
    @(negedge clk); timerPin = 1'b1;
    @(negedge clk); mRun = 1;
    acc(20'h00000, 1'b0, 12'h0);
    @(negedge clk); timerPin = 1'b0;   // toggling back: R2 stays in run mode
    repeat (2) @(negedge clk);
    acc(20'h7FFFF, 1'b1, 12'h0);      // R4 top of SRAM
    // R5 link edges on node A
    acc(20'h80000, 1'b0, 12'h0); acc(20'h8FFFF, 1'b1, 12'h0);
    acc(20'h90000, 1'b0, 12'h0); acc(20'hA0000, 1'b0, 12'h0); acc(20'hAFFFF, 1'b0, 12'h0);
    // R7 bridge registers and interrupt-acknowledge
    acc(20'hB0000, 1'b1, 12'h0); acc(20'hB07FF, 1'b0, 12'h0); acc(20'hB0800, 1'b0, 12'h0);
    acc(20'hB8000, 1'b1, 12'h0); acc(20'hBC000, 1'b0, 12'h0); acc(20'hBFFFF, 1'b1, 12'h0);
    // R10 single-cycle pulse
    @(negedge clk);
    chk(errPulse == 1'b0, "R10 error lasts one cycle", errPulse, 0);
    // R8 page register then R9 window
    acc(20'hB4000, 1'b1, 12'h5A3); acc(20'hB5FFF, 1'b0, 12'h0);
    acc(20'hC0000, 1'b0, 12'h0); acc(20'hFFFFF, 1'b1, 12'h0);
    // R6 node B/C/D
    @(negedge clk); nodeA = 1'b0;
    acc(20'h80000, 1'b0, 12'h0); acc(20'h90000, 1'b1, 12'h0); acc(20'hAFFFF, 1'b0, 12'h0);
    // random, both straps
    for (int i = 0; i < 600; i++) begin
      if (i == 300) begin @(negedge clk); nodeA = 1'b1; end
      acc(20'($urandom), 1'($urandom), 12'($urandom));
    end
    // R2 reference sampled at release: pin held high, no edge -> boot
    doReset(1'b1);
    acc(20'h00000, 1'b0, 12'h0);
    chk(vmeAddr[31:20] == 12'h0, "R8 page reset", vmeAddr[31:20], 0);
    @(negedge clk); timerPin = 1'b0;
    @(negedge clk); mRun = 1;
    acc(20'h40000, 1'b0, 12'h0);
    for (int i = 0; i < 300; i++) acc(20'($urandom), 1'($urandom), 12'($urandom));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule